// File: doc/BRIEF.md
# Vectored Interrupt Input Port

This block is an input peripheral that sits on a simple processor bus. An outside source presents a word and pulses a load strobe. The port keeps the word in a capture register that is decoded at a fixed bus address. It then raises an interrupt request and holds it until the processor services it. The processor may sample the request only at an instruction boundary, so the request stays high until the captured word has been read.

When the processor acknowledges the interrupt, the port places its own service-routine vector on the shared read-data lines. The processor then jumps to that routine. The routine reads the capture register, and that read alone withdraws the request. If a second word arrives before the first has been read, the newer word replaces it and a sticky overrun bit is set. This bit can be read at the address just above the capture register.

The read-data lines are driven only while the block has something to say. Outside the acknowledge phase and reads of its own two addresses, the output enable stays low.

Top module: `vec_irq_port`

## Requirements
- R1: After reset the interrupt request, the overrun bit and the output enable are all low.
- R2: A load strobe sampled at a rising edge stores the load data in the capture register, and the interrupt request is high from that edge on.
- R3: Once high, the interrupt request stays high on every following edge until a read of the capture address (0x8000) is sampled; reads of other addresses and acknowledges do not lower it.
- R4: A read of 0x8000 drives the capture register onto the read-data lines in the same cycle, and the request is low after that edge; if a load strobe is sampled at the same edge, the new word is stored and the request stays high.
- R5: While the acknowledge input is high, the read-data lines carry the vector parameter (default 16) with the output enable high, whatever read is in progress.
- R6: A load strobe sampled while the request is high, with no read of 0x8000 at that edge, overwrites the capture register and sets the overrun bit, read as bit 0 at address 0x8001 with all higher bits zero.
- R7: A read of 0x8001 clears the overrun bit at that edge, unless a new overrun is detected at the same edge, in which case the bit stays set.
- R8: With no acknowledge and no read of 0x8000 or 0x8001, the output enable is low, and such bus cycles change neither the request nor the stored data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_stb | input | 1 | One-cycle strobe marking new incoming data |
| load_data | input | DATA_W | Incoming data word |
| bus_addr | input | ADDR_W | Processor bus address |
| bus_rd | input | 1 | Processor read enable |
| irq_ack | input | 1 | Interrupt acknowledge from the processor |
| bus_rdata | output | DATA_W | Read-data lines, valid while bus_oe is high |
| bus_oe | output | 1 | Output enable for the shared read-data lines |
| irq_req | output | 1 | Registered interrupt request |

## Verification
The read-data lines and their enable depend on the inputs and on the stored state in the same cycle. They are checked a short settle time after the inputs change, before the next rising edge. The request, the overrun bit and the capture register change only at an edge. Their effect is therefore checked in the cycle after the strobe or read that caused it: the request is due one edge after a strobe, and the overrun value is seen on the first read of 0x8001 after the edge that set it. A behavioural model updates its state right after each rising edge and is compared with the ports in every cycle. This catches both early and late changes.

// File: rtl/vip_pkg.sv
package vip_pkg;
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_VEC  = 2'd1,
      SRC_DATA = 2'd2,
      SRC_OVR  = 2'd3
   } bus_src_e;
endpackage

// File: rtl/vip_capture.sv
module vip_capture #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (load) q <= din;
   end

   // R2: the word sampled with the strobe is what the register holds next
   p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (q == $past(din)));
   // R8: without a strobe the stored word does not move
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));
endmodule

// File: rtl/vip_request.sv
module vip_request #(
   parameter bit OVR_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   input  logic data_read,
   input  logic ovr_read,
   output logic irq_q,
   output logic ovr_q
);
   logic ovr_hit;
   assign ovr_hit = strobe && irq_q && !data_read;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         irq_q <= 1'b0;
      else if (strobe)    irq_q <= 1'b1;
      else if (data_read) irq_q <= 1'b0;
   end

   generate
      if (OVR_EN) begin : g_ovr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        ovr_q <= 1'b0;
            else if (ovr_hit)  ovr_q <= 1'b1;
            else if (ovr_read) ovr_q <= 1'b0;
         end
         // R6: a strobe over a pending request leaves the overrun bit set
         p_ovr_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (strobe && irq_q && !data_read) |=> ovr_q);
         // R7: a read of the overrun address with no new overrun clears it
         p_ovr_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (ovr_read && !(strobe && irq_q && !data_read)) |=> !ovr_q);
      end else begin : g_no_ovr
         assign ovr_q = 1'b0;
      end
   endgenerate

   // R2: request high after any strobe
   p_req_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> irq_q);
   // R3: request is held until the capture register is read
   p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !data_read) |=> irq_q);
   // R4: a capture read without a new strobe withdraws the request
   p_req_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (data_read && !strobe) |=> !irq_q);
endmodule

// File: rtl/vip_bus_mux.sv
module vip_bus_mux
   import vip_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int VECTOR = 16
) (
   input  bus_src_e          src,
   input  logic [DATA_W-1:0] data_q,
   input  logic              ovr_q,
   output logic [DATA_W-1:0] rdata,
   output logic              oe
);
   localparam logic [DATA_W-1:0] VEC_WORD = DATA_W'(VECTOR);

   always_comb begin
      oe    = 1'b1;
      rdata = '0;
      unique case (src)
         SRC_VEC:  rdata = VEC_WORD;
         SRC_DATA: rdata = data_q;
         SRC_OVR:  rdata = {{(DATA_W-1){1'b0}}, ovr_q};
         default:  oe    = 1'b0;
      endcase
   end
endmodule

// File: rtl/vec_irq_port.sv
module vec_irq_port
   import vip_pkg::*;
#(
   parameter int              DATA_W    = 8,
   parameter int              ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h8000,
   parameter int              VECTOR    = 16,
   parameter bit              OVR_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_stb,
   input  logic [DATA_W-1:0] load_data,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              irq_ack,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_oe,
   output logic              irq_req
);
   localparam logic [ADDR_W-1:0] OVR_ADDR = BASE_ADDR + ADDR_W'(1);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("vec_irq_port: DATA_W must be at least 1");
      end
      if (VECTOR < 0 || VECTOR >= (1 << DATA_W)) begin : g_bad_vector
         $error("vec_irq_port: VECTOR does not fit in DATA_W bits");
      end
      if (OVR_EN && (BASE_ADDR == '1)) begin : g_bad_base
         $error("vec_irq_port: overrun address wraps past the top");
      end
   endgenerate

   logic              data_read;
   logic              ovr_read;
   logic [DATA_W-1:0] data_q;
   logic              ovr_q;
   bus_src_e          src;

   assign data_read = bus_rd && (bus_addr == BASE_ADDR);

   generate
      if (OVR_EN) begin : g_ovr_dec
         assign ovr_read = bus_rd && (bus_addr == OVR_ADDR);
      end else begin : g_no_ovr_dec
         assign ovr_read = 1'b0;
      end
   endgenerate

   always_comb begin
      if (irq_ack)        src = SRC_VEC;
      else if (data_read) src = SRC_DATA;
      else if (ovr_read)  src = SRC_OVR;
      else                src = SRC_NONE;
   end

   vip_capture #(.DATA_W(DATA_W)) i_capture (
      .clk  (clk),
      .rst_n(rst_n),
      .load (load_stb),
      .din  (load_data),
      .q    (data_q)
   );

   vip_request #(.OVR_EN(OVR_EN)) i_request (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe   (load_stb),
      .data_read(data_read),
      .ovr_read (ovr_read),
      .irq_q    (irq_req),
      .ovr_q    (ovr_q)
   );

   vip_bus_mux #(.DATA_W(DATA_W), .VECTOR(VECTOR)) i_bus_mux (
      .src   (src),
      .data_q(data_q),
      .ovr_q (ovr_q),
      .rdata (bus_rdata),
      .oe    (bus_oe)
   );

   // R5: acknowledge always puts the vector on the bus
   p_vector_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |-> (bus_oe && (bus_rdata == DATA_W'(VECTOR))));
   // R8: with no acknowledge and no read the bus is released
   p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_ack && !bus_rd) |-> !bus_oe);
   // R1: outputs quiet right after reset is released
   p_reset_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (!irq_req && !ovr_q));
endmodule

// File: tb/test_vec_irq_port.sv
module test_vec_irq_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_stb = 1'b0;
   logic [7:0]  load_data = '0;
   logic [15:0] bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        irq_ack = 1'b0;
   logic [7:0]  bus_rdata;
   logic        bus_oe;
   logic        irq_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // behavioural reference state
   logic [7:0] m_data = '0;
   logic       m_irq = 1'b0;
   logic       m_ovr = 1'b0;

   always #5 clk = ~clk;

   vec_irq_port i_vec_irq_port (
      .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .load_data(load_data),
      .bus_addr(bus_addr), .bus_rd(bus_rd), .irq_ack(irq_ack),
      .bus_rdata(bus_rdata), .bus_oe(bus_oe), .irq_req(irq_req)
   );

   task automatic chk(input string tag, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // one bus cycle: drive at the falling edge, compare, then advance the model
   task automatic step(input logic stb, input logic [7:0] d, input logic rd,
                       input logic [15:0] a, input logic ack, input string tag);
      logic       e_oe;
      logic [7:0] e_dout;
      logic       hit_d, hit_o;
      logic [7:0] n_data;
      logic       n_irq, n_ovr;
      load_stb = stb; load_data = d; bus_rd = rd; bus_addr = a; irq_ack = ack;
      #1;
      hit_d  = rd && (a == 16'h8000);
      hit_o  = rd && (a == 16'h8001);
      e_oe   = ack || hit_d || hit_o;
      e_dout = ack ? 8'd16 : hit_d ? m_data : hit_o ? {7'd0, m_ovr} : 8'd0;
      chk(tag, "irq_req", {7'd0, irq_req}, {7'd0, m_irq});
      chk(tag, "bus_oe",  {7'd0, bus_oe},  {7'd0, e_oe});
      if (e_oe) chk(tag, "bus_rdata", bus_rdata, e_dout);
      n_data = stb ? d : m_data;
      n_irq  = stb ? 1'b1 : (hit_d ? 1'b0 : m_irq);
      n_ovr  = (stb && m_irq && !hit_d) ? 1'b1 : (hit_o ? 1'b0 : m_ovr);
      @(posedge clk);
      m_data = n_data; m_irq = n_irq; m_ovr = n_ovr;
      @(negedge clk);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b0, 16'h0000, 1'b0, tag);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values, also while held
      chk("R1", "irq_req in reset", {7'd0, irq_req}, 8'd0);
      chk("R1", "bus_oe in reset",  {7'd0, bus_oe},  8'd0);
      rst_n = 1'b1;
      idle(2, "R1");
      step(1'b0, 8'h00, 1'b1, 16'h8001, 1'b0, "R1");   // overrun reads 0
      // R2: capture and raise
      step(1'b1, 8'hA5, 1'b0, 16'h0000, 1'b0, "R2");
      idle(3, "R3");
      // R8 / R3: foreign reads do not drive or clear
      step(1'b0, 8'h00, 1'b1, 16'h8002, 1'b0, "R8");
      step(1'b0, 8'h00, 1'b1, 16'h0000, 1'b0, "R8");
      step(1'b0, 8'h00, 1'b0, 16'h8000, 1'b0, "R8");  // address without read
      // R5: vector during acknowledge, request unaffected
      step(1'b0, 8'h00, 1'b0, 16'h0000, 1'b1, "R5");
      step(1'b0, 8'h00, 1'b0, 16'h0000, 1'b1, "R5");
      idle(1, "R3");
      // R4: read clears
      step(1'b0, 8'h00, 1'b1, 16'h8000, 1'b0, "R4");
      idle(2, "R4");
      step(1'b0, 8'h00, 1'b1, 16'h8000, 1'b0, "R8");  // read with nothing pending
      // R6: overrun
      step(1'b1, 8'h11, 1'b0, 16'h0000, 1'b0, "R6");
      step(1'b1, 8'h22, 1'b0, 16'h0000, 1'b0, "R6");
      step(1'b0, 8'h00, 1'b1, 16'h8001, 1'b0, "R6");
      // R7: cleared by that read
      step(1'b0, 8'h00, 1'b1, 16'h8001, 1'b0, "R7");
      step(1'b0, 8'h00, 1'b1, 16'h8000, 1'b0, "R6");  // newest word kept
      // R4: strobe and read at the same edge
      step(1'b1, 8'h33, 1'b0, 16'h0000, 1'b0, "R4");
      step(1'b1, 8'h44, 1'b1, 16'h8000, 1'b0, "R4");
      step(1'b0, 8'h00, 1'b1, 16'h8001, 1'b0, "R4");  // no overrun
      step(1'b0, 8'h00, 1'b1, 16'h8000, 1'b0, "R4");
      idle(1, "R4");
      // R5: acknowledge wins over a capture read
      step(1'b1, 8'h5A, 1'b0, 16'h0000, 1'b0, "R5");
      step(1'b0, 8'h00, 1'b1, 16'h8000, 1'b1, "R5");
      idle(1, "R5");
      // R7: overrun set and cleared at the same edge keeps it set
      step(1'b1, 8'h66, 1'b0, 16'h0000, 1'b0, "R7");
      step(1'b1, 8'h77, 1'b1, 16'h8001, 1'b0, "R7");
      step(1'b0, 8'h00, 1'b1, 16'h8001, 1'b0, "R7");
      step(1'b0, 8'h00, 1'b1, 16'h8001, 1'b0, "R7");
      step(1'b0, 8'h00, 1'b1, 16'h8000, 1'b0, "R2");
      idle(2, "R8");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule